// File: doc/BRIEF.md
# I2C Slave Read-Data Transmitter with Clock Stretching

This block is the data-sending half of an I2C slave. Once local logic has decided that the master is reading from this slave, it raises `start_read`. The block then shifts bytes out on SDA, most significant bit first, and checks the master's acknowledge on the ninth clock of each byte. Both bus lines are open-drain: each output only asks for its line to be pulled low, and a low output leaves the line released.

Local logic hands each byte over by writing a one-byte transmit buffer. It grants the bus clock through a release flag, which reads 1 out of reset.

When the master acknowledges a byte, the block clears the release flag by itself. From the falling edge of that ninth clock it holds SCL low. The hold lasts until the buffer has been refilled and the release flag has been set again. A not-acknowledge ends the read at once: the release flag is left alone, SCL is never held, and the read status drops. A stop condition on the bus always returns the block to idle with both lines released.

Top module: `i2c_slave_tx_stretch`

## Requirements
- R1: After reset, neither line is pulled low, `rw_o` is 0, `rel_o` is 1 and `byte_done_o` is 0.
- R2: Each byte is driven on SDA most significant bit first. `sda_low_o` = 1 encodes a 0 bit. The level driven on SDA changes only while SCL is low.
- R3: The master's acknowledge is sampled on the rising edge of the ninth SCL clock. `byte_done_o` pulses for exactly one cycle there. If the acknowledge is ACK (SDA low), `rel_o` is cleared in that same cycle.
- R4: After an ACK, SCL is pulled low from the ninth falling edge onward. It stays low while the buffer alone has been written or the release flag alone has been set. It is released only once both have happened, and the next byte then shifts out.
- R5: After a NACK (SDA high on the ninth clock), `rel_o` stays 1, `rw_o` goes to 0 and SCL is never pulled low.
- R6: A stop condition (SDA rising while SCL is high) in any active state returns the block to idle. Both lines are released and `rw_o` is 0.
- R7: `start_read` sets `rw_o` to 1. If the buffer is empty at that point, SCL is held low until it is written and the release flag is 1.
- R8: During the ninth SCL clock the block does not pull SDA low, so that the master can drive the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| start_read | input | 1 | Pulse: address matched with read direction |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Byte written into the transmit buffer |
| rel_set | input | 1 | Pulse: set the clock-release flag |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rel_o | output | 1 | Clock-release flag |
| rw_o | output | 1 | Read status, 1 while a master read is active |
| byte_done_o | output | 1 | One-cycle pulse when the acknowledge is sampled |

## Verification
The bench models a master on a wired-AND bus and goes after the stretch window. It checks that SCL stays low when only the buffer has been written. A design that released on either condition alone would let the master clock out stale data. After a NACK it confirms that the release flag is untouched and that SCL runs free. A design that treated NACK like ACK would hang the bus, or would leave the read status stuck at 1. It also issues a stop in the middle of a byte and a start with an empty buffer, the cases where a design that ignored the stop, or that sent before data was loaded, would misbehave.

// File: rtl/i2cst_pkg.sv
// Package: shared state encoding for the I2C slave transmit path.
// Assumes: imported by the FSM only; no other shared types.
package i2cst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // no read active, lines released
        ST_HOLD,     // SCL held low until a byte is ready
        ST_SETUP,    // first bit placed on SDA, SCL still held
        ST_DATA,     // shifting bits on SCL falling edges
        ST_ACKW,     // SDA released, waiting for ninth rising edge
        ST_ACKFALL,  // ACK seen, waiting for ninth falling edge
        ST_NACKW     // NACK seen, waiting for stop or new read
    } tx_state_e;
endpackage

// File: rtl/i2cst_sync.sv
// Module: multi-stage synchronizer for bus line inputs.
// Also gives the previous synchronized level so that the consumer can
// form edges. Assumes the lines idle high, so every stage resets to 1.
module i2cst_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] lvl_d_o
);
    localparam int LAST = STAGES - 1;

    logic [LINES-1:0] stage_q [STAGES];
    logic [LINES-1:0] prev_q;

    // Shift the raw line levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Keep one extra copy of the synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= stage_q[LAST];
    end

    assign lvl_o   = stage_q[LAST];
    assign lvl_d_o = prev_q;
endmodule

// File: rtl/i2cst_txbuf.sv
// Module: one-entry transmit buffer and clock-release flag.
// The flag is set by local logic and cleared by an acknowledge event.
// A clear wins over a set in the same cycle. The buffer is full from a
// write until the FSM takes the byte.
module i2cst_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rel_set_i,
    input  logic              rel_clr_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] buf_o,
    output logic              ready_o,
    output logic              rel_o
);
    logic [DATA_W-1:0] buf_q;
    logic              full_q;
    logic              rel_q;

    // Capture written bytes and track whether one is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            full_q <= 1'b0;
        end else if (wr_i) begin
            buf_q  <= data_i;
            full_q <= 1'b1;
        end else if (take_i) begin
            full_q <= 1'b0;
        end
    end

    // Clock-release flag: out of reset it is set, an ACK clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         rel_q <= 1'b1;
        else if (rel_clr_i) rel_q <= 1'b0;
        else if (rel_set_i) rel_q <= 1'b1;
    end

    assign buf_o   = buf_q;
    assign ready_o = full_q && rel_q;
    assign rel_o   = rel_q;

    // R3: an acknowledge event always leaves the flag cleared.
    a_r3_ack_clears_rel: assert property (@(posedge clk) disable iff (!rst_n)
        rel_clr_i |=> !rel_q);
endmodule

// File: rtl/i2cst_fsm.sv
// Module: bit sequencer of the slave transmit path.
// Shifts a byte out MSB first and changes SDA only after a synchronized
// SCL fall. It samples the acknowledge on the ninth rise and stretches
// SCL while no byte is ready. Assumes the master holds SCL low when
// start_read arrives.
module i2cst_fsm
    import i2cst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              scl_prev_i,
    input  logic              sda_lvl_i,
    input  logic              sda_prev_i,
    input  logic              start_read_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] buf_i,
    output logic              take_o,
    output logic              ack_evt_o,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic              rw_o,
    output logic              done_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int MSB   = DATA_W - 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_e         state_q;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sda_low_q;
    logic              rw_q;
    logic              done_q;

    logic scl_rise, scl_fall, sda_rise, stop_det;

    // Edge and stop-condition detection on the synchronized levels.
    always_comb begin
        scl_rise = scl_lvl_i && !scl_prev_i;
        scl_fall = !scl_lvl_i && scl_prev_i;
        sda_rise = sda_lvl_i && !sda_prev_i;
        stop_det = sda_rise && scl_lvl_i;
    end

    // A byte is taken only while SCL is low and local logic is ready.
    assign take_o    = (state_q == ST_HOLD) && ready_i && !scl_lvl_i && !stop_det;
    assign ack_evt_o = (state_q == ST_ACKW) && scl_rise && !sda_lvl_i && !stop_det;

    // Main sequencer: states, shift register, SDA drive and read status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sh_q      <= '0;
            cnt_q     <= '0;
            sda_low_q <= 1'b0;
            rw_q      <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (stop_det && state_q != ST_IDLE) begin
                state_q   <= ST_IDLE;
                sda_low_q <= 1'b0;
                rw_q      <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE, ST_NACKW: begin
                        if (start_read_i) begin
                            rw_q    <= 1'b1;
                            state_q <= ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (take_o) begin
                            sh_q      <= buf_i;
                            sda_low_q <= !buf_i[MSB];
                            cnt_q     <= '0;
                            state_q   <= ST_SETUP;
                        end
                    end
                    ST_SETUP: state_q <= ST_DATA;
                    ST_DATA: begin
                        if (scl_fall) begin
                            if (cnt_q == LAST_BIT) begin
                                sda_low_q <= 1'b0;
                                state_q   <= ST_ACKW;
                            end else begin
                                sh_q      <= {sh_q[MSB-1:0], 1'b0};
                                sda_low_q <= !sh_q[MSB-1];
                                cnt_q     <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_ACKW: begin
                        if (scl_rise) begin
                            done_q <= 1'b1;
                            if (!sda_lvl_i) begin
                                state_q <= ST_ACKFALL;
                            end else begin
                                rw_q    <= 1'b0;
                                state_q <= ST_NACKW;
                            end
                        end
                    end
                    ST_ACKFALL: begin
                        if (scl_fall) state_q <= ST_HOLD;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign scl_low_o = (state_q == ST_HOLD) || (state_q == ST_SETUP);
    assign sda_low_o = sda_low_q;
    assign rw_o      = rw_q;
    assign done_o    = done_q;

    // R2: while SCL stays high inside a transfer, the SDA drive is steady.
    a_r2_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl_i && scl_prev_i && state_q != ST_IDLE && !stop_det) |=> $stable(sda_low_q));
    // R3: the acknowledge-sample pulse lasts a single cycle.
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R6: a stop leaves the block idle with SDA released.
    a_r6_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && state_q != ST_IDLE) |=> (state_q == ST_IDLE && !sda_low_q && !rw_q));
    // R8: SDA is never pulled low while waiting for the acknowledge.
    a_r8_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACKW) |-> !sda_low_q);
endmodule

// File: rtl/i2c_slave_tx_stretch.sv
// Module: top of the I2C slave transmit path with clock stretching.
// It wires the line synchronizer, the transmit buffer with its release
// flag, and the bit sequencer. Outputs are open-drain requests: 1 pulls
// a line low.
module i2c_slave_tx_stretch #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_read,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rel_set,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic              rel_o,
    output logic              rw_o,
    output logic              byte_done_o
);
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;

    logic [1:0]        lvl, lvl_d;
    logic [DATA_W-1:0] buf_data;
    logic              ready, take, ack_evt;

    i2cst_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sda_i, scl_i}),
        .lvl_o   (lvl),
        .lvl_d_o (lvl_d)
    );

    i2cst_txbuf #(.DATA_W(DATA_W)) u_txbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (tx_wr),
        .data_i    (tx_data),
        .rel_set_i (rel_set),
        .rel_clr_i (ack_evt),
        .take_i    (take),
        .buf_o     (buf_data),
        .ready_o   (ready),
        .rel_o     (rel_o)
    );

    i2cst_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_lvl_i    (lvl[SCL_IDX]),
        .scl_prev_i   (lvl_d[SCL_IDX]),
        .sda_lvl_i    (lvl[SDA_IDX]),
        .sda_prev_i   (lvl_d[SDA_IDX]),
        .start_read_i (start_read),
        .ready_i      (ready),
        .buf_i        (buf_data),
        .take_o       (take),
        .ack_evt_o    (ack_evt),
        .scl_low_o    (scl_low_o),
        .sda_low_o    (sda_low_o),
        .rw_o         (rw_o),
        .done_o       (byte_done_o)
    );

    // R4: once SCL is held during a read, it stays held while the flag is clear.
    a_r4_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_low_o) && !rel_o && rw_o) |-> scl_low_o);
    // R5: no SCL hold ever happens without an active read.
    a_r5_no_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_o |-> !scl_low_o);
    // R5: a NACK leaves the release flag set.
    a_r5_nack_keeps_rel: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_o && !rw_o) |-> rel_o);
    // R3: an ACK result leaves the release flag cleared.
    a_r3_ack_rel_low: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_o && rw_o) |-> !rel_o);
endmodule

// File: tb/i2c_slave_tx_stretch_bench.sv
module i2c_slave_tx_stretch_bench;
    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_read = 1'b0, tx_wr = 1'b0, rel_set = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       scl_low_o, sda_low_o, rel_o, rw_o, byte_done_o;
    wire        scl_line = !(m_scl_low || scl_low_o);
    wire        sda_line = !(m_sda_low || sda_low_o);
    int         checks = 0, fails = 0, done_cnt = 0;
    logic       ack_phase_sda_low = 1'b0;

    always #5 clk = ~clk;

    i2c_slave_tx_stretch u_i2c_slave_tx_stretch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .start_read(start_read), .tx_wr(tx_wr), .tx_data(tx_data), .rel_set(rel_set),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .rel_o(rel_o),
        .rw_o(rw_o), .byte_done_o(byte_done_o)
    );

    always @(posedge clk) if (rst_n && byte_done_o) done_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int n = 0;
        while (!scl_line && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_wr(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pulse_rel();
        @(negedge clk); rel_set = 1'b1;
        @(negedge clk); rel_set = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_read = 1'b1;
        @(negedge clk); start_read = 1'b0;
    endtask

    // Master clocks out one byte and answers with ACK (ack=1) or NACK.
    task automatic rd_byte(output logic [7:0] b, input logic ack);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            m_scl_low = 1'b0; wait_scl_high(); ticks(HALF);
            b = {b[6:0], sda_line};
            m_scl_low = 1'b1; ticks(HALF);
        end
        m_sda_low = ack;
        m_scl_low = 1'b0; wait_scl_high(); ticks(HALF);
        ack_phase_sda_low = sda_low_o;
        m_scl_low = 1'b1; ticks(4);
        m_sda_low = 1'b0; ticks(HALF - 4);
    endtask

    task automatic do_stop();
        m_scl_low = 1'b1; ticks(HALF);
        m_sda_low = 1'b1; ticks(HALF);
        m_scl_low = 1'b0; ticks(HALF);
        m_sda_low = 1'b0; ticks(HALF);
    endtask

    task automatic t_reset();
        ticks(2);
        check("R1 scl release", scl_low_o, 0);
        check("R1 sda release", sda_low_o, 0);
        check("R1 rw", rw_o, 0);
        check("R1 rel", rel_o, 1);
        check("R1 byte_done", byte_done_o, 0);
    endtask

    task automatic t_first_byte();
        logic [7:0] b; int d0;
        pulse_wr(8'hA5);
        m_scl_low = 1'b1;
        pulse_start();
        check("R7 rw set", rw_o, 1);
        d0 = done_cnt;
        rd_byte(b, 1'b1);
        check("R2 first byte", b, 8'hA5);
        check("R3 one done pulse", done_cnt - d0, 1);
        check("R3 rel cleared on ACK", rel_o, 0);
        check("R8 sda released on ninth", ack_phase_sda_low, 0);
    endtask

    task automatic t_stretch();
        logic [7:0] b;
        m_scl_low = 1'b0; ticks(30);
        check("R4 SCL held after ACK", scl_line, 0);
        pulse_wr(8'h3C); ticks(30);
        check("R4 still held, buffer only", scl_line, 0);
        pulse_rel(); ticks(10);
        check("R4 released after rel_set", scl_line, 1);
        rd_byte(b, 1'b0);
        check("R4 byte after stretch", b, 8'h3C);
    endtask

    task automatic t_nack();
        check("R5 rel kept on NACK", rel_o, 1);
        check("R5 rw cleared on NACK", rw_o, 0);
        m_scl_low = 1'b0; ticks(10);
        check("R5 no stretch after NACK", scl_line, 1);
    endtask

    task automatic t_stop_idle();
        do_stop();
        check("R6 scl released", scl_low_o, 0);
        check("R6 sda released", sda_low_o, 0);
    endtask

    task automatic t_empty_start();
        logic [7:0] b;
        m_scl_low = 1'b1;
        pulse_start();
        m_scl_low = 1'b0; ticks(30);
        check("R7 held while buffer empty", scl_line, 0);
        pulse_wr(8'h5A); ticks(10);
        check("R7 released after load", scl_line, 1);
        rd_byte(b, 1'b0);
        check("R7 byte value", b, 8'h5A);
        do_stop();
    endtask

    task automatic t_stop_mid_byte();
        pulse_wr(8'hFF);
        m_scl_low = 1'b1;
        pulse_start();
        ticks(HALF);
        check("R6 rw before stop", rw_o, 1);
        m_sda_low = 1'b1; ticks(10);
        m_scl_low = 1'b0; ticks(10);
        m_sda_low = 1'b0; ticks(10);
        check("R6 rw cleared by stop", rw_o, 0);
        check("R6 sda released by stop", sda_low_o, 0);
        check("R6 scl released by stop", scl_low_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        t_reset();
        t_first_byte();
        t_stretch();
        t_nack();
        t_stop_idle();
        t_empty_start();
        t_stop_mid_byte();
        ticks(5);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule